// File: doc/BRIEF.md
# Clock Source Frequency Watchdog

This block watches a crystal-derived clock and checks that its frequency stays inside a programmable band. The check runs against a fixed internal reference clock of nominal 5 MHz. A free-running binary counter, coded in Gray, counts edges in the supervised clock domain. Its value crosses into the reference domain through a short synchronizer chain. On the reference side a measurement window of 256 reference cycles is timed. At the end of each window the difference between two successive synchronized counts gives the number of supervised edges seen in that window.

After reset, or after a restart strobe, the first window is a settling window and its result is discarded. The second window is the first one judged. At the end of the second window the detection-valid flag rises. If a judged count lies below the minimum limit or above the maximum limit, a sticky fault flag is set and a direction bit records which side was violated. A one-cycle fallback request pulse then asks the clock generator to drop into its free-running mode. The restart strobe re-arms only this watchdog. The supervised-domain counter keeps running, so no other part of the clock system is disturbed.

The reference-side sequencer has four states. ST_START takes the baseline snapshot. ST_WIN1 is the discarded settling window. ST_WIN2 is the first judged window. ST_RUN covers every later window. The transitions are:
- ST_START to ST_WIN1, unconditionally.
- ST_WIN1 to ST_WIN2, at the end of a window.
- ST_WIN2 to ST_RUN, at the end of a window.
- ST_RUN to ST_RUN, at each window end.
- Any state to ST_START, on restart, with priority over every other transition.

Top module: `cfw_watchdog`

## Requirements
- R1: While rst_n is low, det_valid, fault, fault_high and fallback_req are all 0, and the sequencer is in ST_START.
- R2: A window lasts exactly 256 ref_clk cycles. After reset release, the first rising ref_clk edge starts the sequence. det_valid rises on the 513th edge, counting that first edge as number 1, so it follows two complete windows. The first window is never judged.
- R3: A restart sampled high on a ref_clk edge clears det_valid, fault, fault_high and fallback_req on that edge. That edge becomes edge 0 of a new sequence, and the R2 timing then applies again. Restart takes priority over window completion.
- R4: At the end of the second window, and of every later window, the supervised-edge count is compared against the limits. A count below lim_min sets fault with fault_high = 0. A count above lim_max sets fault with fault_high = 1.
- R5: The limits are inclusive. A count equal to lim_min or to lim_max does not set fault.
- R6: fault is never 1 while det_valid is 0.
- R7: fallback_req is high for exactly one ref_clk cycle, on the edge where fault goes from 0 to 1.
- R8: Once set, fault and fault_high hold until restart or reset. In-range windows and changed limits do not clear them.
- R9: Supervised edges are counted by a Gray-coded counter in the sup_clk domain that changes one bit per sup_clk edge. A stopped supervised clock yields a count of 0 and therefore a below-minimum fault.
- R10: The limits are sampled on the window-end edge. A limit change made during a window applies to that window's judgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, nominal 5 MHz |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sup_clk | input | 1 | Supervised crystal-derived clock |
| restart | input | 1 | Watchdog re-arm strobe, ref_clk domain |
| lim_min | input | CNT_W | Smallest acceptable edge count per window |
| lim_max | input | CNT_W | Largest acceptable edge count per window |
| det_valid | output | 1 | Detection result is valid |
| fault | output | 1 | Sticky out-of-band fault |
| fault_high | output | 1 | Direction of the recorded fault: 1 = too fast |
| fallback_req | output | 1 | One-cycle request to enter free-running mode |

## Verification
The first check uses a supervised clock at exactly twice the reference rate, phased so that no edges coincide, which gives exactly 512 edges per window. With both limits set to 512 it probes the inclusive bounds. A strict comparison would fault on a healthy clock, and an off-by-one window length would land on 511 or 513 and trip. Restarts are issued mid-settle and after a fault. An engine that does not rearm would raise det_valid early or keep a stale fault. A limit change during a running window and a stopped supervised clock catch a design that latches limits at restart or that needs edges to detect a fault. Good windows and relaxed limits after a fault expose a non-sticky flag or a repeating fallback pulse.

// File: rtl/cfw_pkg.sv
`timescale 1ns/1ps
package cfw_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_WIN1  = 2'd1,
        ST_WIN2  = 2'd2,
        ST_RUN   = 2'd3
    } cfw_state_e;

endpackage

// File: rtl/cfw_sup_counter.sv
`timescale 1ns/1ps
module cfw_sup_counter #(
    parameter int CNT_W = 12
) (
    input  logic             sup_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);

    logic [1:0]       rst_pipe;
    logic             sup_rst_n;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;
    logic [CNT_W-1:0] gray_q;

    // reset released synchronously to the supervised clock
    always_ff @(posedge sup_clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= 2'b00;
        else        rst_pipe <= {rst_pipe[0], 1'b1};
    end
    assign sup_rst_n = rst_pipe[1];

    assign bin_nxt = bin_q + 1'b1;

    always_ff @(posedge sup_clk or negedge sup_rst_n) begin
        if (!sup_rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    assign gray_o = gray_q;

    // the crossing value may move by one bit per supervised edge
    assert_gray_one_step_R9: assert property (@(posedge sup_clk) disable iff (!sup_rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1)
        else $error("gray count changed more than one bit");

endmodule

// File: rtl/cfw_gray_sync.sv
`timescale 1ns/1ps
module cfw_gray_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    logic [W-1:0] pipe_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[s] <= '0;
                    else        pipe_q[s] <= gray_i;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[s] <= '0;
                    else        pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        bin_o[W-1] = pipe_q[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ pipe_q[STAGES-1][i];
        end
    end

endmodule

// File: rtl/cfw_fsm.sv
`timescale 1ns/1ps
module cfw_fsm
    import cfw_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int WIN_LEN = 256
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] cnt_bin,
    input  logic [CNT_W-1:0] lim_min,
    input  logic [CNT_W-1:0] lim_max,
    output logic             det_valid,
    output logic             fault,
    output logic             fault_high,
    output logic             fallback_req
);

    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    cfw_state_e       state_q, state_d;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] delta;
    logic             win_end;
    logic             judge;
    logic             too_low, too_high;

    assign win_end  = (win_q == WIN_LAST);
    assign delta    = cnt_bin - base_q;
    assign too_low  = (delta < lim_min);
    assign too_high = (delta > lim_max);
    assign judge    = win_end && ((state_q == ST_WIN2) || (state_q == ST_RUN));

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: state_d = ST_WIN1;
            ST_WIN1:  if (win_end) state_d = ST_WIN2;
            ST_WIN2:  if (win_end) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_START;
        endcase
        if (restart) state_d = ST_START;
    end

    // window timer and baseline snapshot
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            base_q <= '0;
        end else if (restart) begin
            win_q  <= '0;
        end else if (state_q == ST_START) begin
            win_q  <= '0;
            base_q <= cnt_bin;
        end else begin
            win_q <= win_end ? '0 : win_q + 1'b1;
            if (win_end) base_q <= cnt_bin;
        end
    end

    // outputs
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            det_valid    <= 1'b0;
            fault        <= 1'b0;
            fault_high   <= 1'b0;
            fallback_req <= 1'b0;
        end else if (restart) begin
            det_valid    <= 1'b0;
            fault        <= 1'b0;
            fault_high   <= 1'b0;
            fallback_req <= 1'b0;
        end else begin
            fallback_req <= 1'b0;
            if (judge) begin
                det_valid <= 1'b1;
                if ((too_low || too_high) && !fault) begin
                    fault        <= 1'b1;
                    fault_high   <= too_high;
                    fallback_req <= 1'b1;
                end
            end
        end
    end

    assert_valid_after_two_windows_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(det_valid) |-> ($past(state_q) == ST_WIN2))
        else $error("valid rose outside second window end");

    assert_restart_clears_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        restart |=> (!det_valid && !fault && !fallback_req))
        else $error("restart did not clear status");

    assert_fault_implies_valid_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fault |-> det_valid)
        else $error("fault without valid");

    assert_fallback_single_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fallback_req |=> !fallback_req)
        else $error("fallback request longer than one cycle");

    assert_fault_sticky_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fault && !restart) |=> (fault && $stable(fault_high)))
        else $error("fault released without restart");

endmodule

// File: rtl/cfw_watchdog.sv
`timescale 1ns/1ps
module cfw_watchdog #(
    parameter int CNT_W       = 12,
    parameter int WIN_LEN     = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             sup_clk,
    input  logic             restart,
    input  logic [CNT_W-1:0] lim_min,
    input  logic [CNT_W-1:0] lim_max,
    output logic             det_valid,
    output logic             fault,
    output logic             fault_high,
    output logic             fallback_req
);

    logic [CNT_W-1:0] sup_gray;
    logic [CNT_W-1:0] ref_bin;

    cfw_sup_counter #(.CNT_W(CNT_W)) i_counter (
        .sup_clk (sup_clk),
        .rst_n   (rst_n),
        .gray_o  (sup_gray)
    );

    cfw_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) i_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (sup_gray),
        .bin_o   (ref_bin)
    );

    cfw_fsm #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) i_fsm (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .cnt_bin      (ref_bin),
        .lim_min      (lim_min),
        .lim_max      (lim_max),
        .det_valid    (det_valid),
        .fault        (fault),
        .fault_high   (fault_high),
        .fallback_req (fallback_req)
    );

endmodule

// File: tb/test_cfw_watchdog.sv
`timescale 1ns/1ps
module test_cfw_watchdog;

    localparam int  REF_PERIOD = 200;
    localparam int  CNT_W      = 12;
    localparam int  WIN        = 256;
    localparam int  MAX_CYC    = 200000;

    logic             ref_clk = 1'b0;
    logic             sup_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             restart = 1'b0;
    logic [CNT_W-1:0] lim_min = 12'd512;
    logic [CNT_W-1:0] lim_max = 12'd512;
    logic             det_valid, fault, fault_high, fallback_req;

    realtime sup_half = 50.0;
    bit      sup_run  = 1'b1;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string tag    = "R1";

    int m_tick  = 0;
    bit m_valid = 0, m_fault = 0, m_fhigh = 0, m_fb = 0;

    cfw_watchdog #(.CNT_W(CNT_W), .WIN_LEN(WIN), .SYNC_STAGES(2)) i_cfw_watchdog (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .sup_clk      (sup_clk),
        .restart      (restart),
        .lim_min      (lim_min),
        .lim_max      (lim_max),
        .det_valid    (det_valid),
        .fault        (fault),
        .fault_high   (fault_high),
        .fallback_req (fallback_req)
    );

    initial forever #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    initial begin
        #37;
        forever begin
            #(sup_half);
            if (sup_run) sup_clk = ~sup_clk;
        end
    end

    // behavioural reference: edges since (re)start, window ends at 1 + 256*m
    always @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tick = 0; m_valid = 0; m_fault = 0; m_fhigh = 0; m_fb = 0;
        end else if (restart) begin
            m_tick = 0; m_valid = 0; m_fault = 0; m_fhigh = 0; m_fb = 0;
        end else begin
            real edges;
            m_tick = m_tick + 1;
            m_fb   = 0;
            edges  = sup_run ? (real'(WIN) * REF_PERIOD) / (2.0 * sup_half) : 0.0;
            if (m_tick >= 2 * WIN + 1 && ((m_tick - 1) % WIN) == 0) begin
                m_valid = 1;
                if (!m_fault && (edges < real'(lim_min) || edges > real'(lim_max))) begin
                    m_fault = 1;
                    m_fhigh = (edges > real'(lim_max));
                    m_fb    = 1;
                end
            end
        end
    end

    task automatic check_bit(input string what, input logic act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge ref_clk) begin
        if (cmp_on && !done) begin
            check_bit("det_valid",    det_valid,    m_valid);
            check_bit("fault",        fault,        m_fault);
            check_bit("fault_high",   fault_high,   m_fault ? m_fhigh : 1'b0);
            check_bit("fallback_req", fallback_req, m_fb);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic pulse_restart;
        @(negedge ref_clk) restart = 1'b1;
        @(negedge ref_clk) restart = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(REF_PERIOD * MAX_CYC);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: outputs idle under reset
        wait_cyc(3);
        tag = "R1";
        cmp_on = 1'b1;
        wait_cyc(2);
        // R2 R5: exact 512 edges per window, limits both 512, inclusive
        tag = "R2/R5 exact count on both bounds";
        rst_n = 1'b1;
        wait_cyc(1100);
        // R4 R7: max below count -> high fault with single pulse
        tag = "R4/R7 high fault";
        lim_max = 12'd511;
        pulse_restart();
        wait_cyc(800);
        // R8: relaxed limits do not clear the fault
        tag = "R8 sticky";
        lim_max = 12'd600;
        wait_cyc(600);
        // R4: min above count -> low fault
        tag = "R4 low fault";
        lim_min = 12'd513;
        pulse_restart();
        wait_cyc(800);
        // R10: limit moved mid-run applies at the next window end
        tag = "R10 limit change in window";
        lim_min = 12'd400;
        pulse_restart();
        wait_cyc(650);
        lim_min = 12'd520;
        wait_cyc(400);
        // R3: restart during settling and after valid
        tag = "R3 restart mid settle";
        lim_min = 12'd400;
        pulse_restart();
        wait_cyc(300);
        pulse_restart();
        wait_cyc(700);
        // 8 MHz supervised clock, in band
        tag = "R4 in band 8 MHz";
        sup_half = 62.5;
        lim_min = 12'd380;
        lim_max = 12'd440;
        pulse_restart();
        wait_cyc(900);
        // 4 MHz, too slow
        tag = "R4 slow clock";
        sup_half = 125.0;
        pulse_restart();
        wait_cyc(900);
        // R9: stopped supervised clock
        tag = "R9 stopped clock";
        sup_run = 1'b0;
        pulse_restart();
        wait_cyc(900);
        // R1: asynchronous reset in the middle of a run
        tag = "R1 reset mid run";
        sup_run = 1'b1;
        sup_half = 62.5;
        @(negedge ref_clk) rst_n = 1'b0;
        wait_cyc(3);
        @(negedge ref_clk) rst_n = 1'b1;
        tag = "R2 after reset";
        wait_cyc(900);
        finish_run();
    end

endmodule